// File: doc/BRIEF.md
# Configurable-Framing Serial Transmitter

This block sends bytes on one asynchronous serial line. Software writes a line-control value that sets four things: the word length (5 to 8 bits), whether a parity bit is sent, the parity rule, and the stop length. Software then writes data bytes into a one-entry holding register. The block moves each byte into a shift register and sends it as a frame. The frame is a low start bit, then the data bits with the least significant bit first, then the optional parity bit, then a high stop period. The line stays high while idle.

The holding register and the shift register work in tandem. While one byte is shifting out, the next can be written. It moves into the shift register at the end of the current stop period, so the next start bit follows with no idle gap. An active-low ready output and a status register tell software when the holding register is free and when the whole transmitter has gone quiet. Bit time comes from an external baud enable, with a fixed number of enables per bit.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, reading address 3 returns 0x00, reading address 5 returns 0x60, `tx_ready_n` is 0 and `ser_out` is 1.
- R2: A frame is one start bit of 0, then the data bits least significant first, then the parity bit when enabled, then stop bits of 1. The line is 1 whenever no frame is in progress.
- R3: Control bits [1:0] set the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Only that many low bits of the written byte are sent.
- R4: When control bit 2 is 0, the stop period is one bit time. When it is 1, the stop period is 1.5 bit times for 5-bit words and 2 bit times for longer words.
- R5: Control bit 3 enables the parity bit. When it is 0, the stop period follows the last data bit directly. Control bit 4 picks the parity rule: 1 makes the count of ones over the data and parity bits even, and 0 makes it odd.
- R6: When control bits 3 and 5 are both 1, the parity bit is forced to the inverse of control bit 4, whatever the data.
- R7: Each bit lasts exactly TICKS_PER_BIT cycles in which `baud_tick` is high. Cycles without `baud_tick` do not advance the frame.
- R8: Reading address 5 gives status. Bit 5 is 1 when the holding register is empty. Bit 6 is 1 when both the holding register and the shift register are empty. All other status bits read 0. Address 3 reads back the six control bits, and any other address reads 0.
- R9: `tx_ready_n` is 0 exactly when the holding register is empty. A byte written while the line is idle starts its frame on the next cycle. A byte written while a frame is in progress starts its frame in the cycle that frame's stop period ends.
- R10: A write to address 0 while the holding register is full is dropped, and no frame is ever sent for it.
- R11: A write to address 3 takes effect at the next frame start. The frame already in progress keeps the settings it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle baud enable, TICKS_PER_BIT per bit |
| reg_addr | input | ADDR_W | Register address for both writes and reads |
| reg_wr | input | 1 | Write strobe: address 0 is the holding register, address 3 the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ser_out | output | 1 | Serial line, high when idle |
| tx_ready_n | output | 1 | Low when the holding register can take a byte |

## Verification
The bench builds the block with its default values: TICKS_PER_BIT of 16 and the default addresses 0, 3 and 5. Frames of up to 12 bit times therefore take only a few hundred cycles, and every word length, parity rule and stop length can be run in one short pass. The bench spaces `baud_tick` one cycle apart for most frames and three cycles apart for some frames. The three-cycle spacing shows that the frame counts enables rather than clock cycles. At a tick count of 16, the 1.5-bit stop period lands on a whole number of enables (24), so the monitor can check every bit boundary and the back-to-back handover at exact tick positions.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int TICKS_PER_BIT = 16,
  parameter int ADDR_W        = 3,
  parameter int THR_ADDR      = 0,
  parameter int LCR_ADDR      = 3,
  parameter int LSR_ADDR      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              ser_out,
  output logic              tx_ready_n
);
  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
  localparam int LW    = CNT_W + 1;
  localparam logic [LW-1:0] ONE_BIT_M1   = LW'(TICKS_PER_BIT - 1);
  localparam logic [LW-1:0] ONE_HALF_M1  = LW'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [LW-1:0] TWO_BITS_M1  = LW'(2 * TICKS_PER_BIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} tx_state_t;

  tx_state_t        state;
  logic [5:0]       ctrl;
  logic [7:0]       hold;
  logic             hold_full;
  logic [7:0]       shreg;
  logic [CNT_W-1:0] tick_cnt;
  logic [2:0]       bit_idx;
  logic [1:0]       f_wl;
  logic             f_stop, f_pen, f_par;

  logic [7:0]    wmask;
  logic          par_calc;
  logic [LW-1:0] span_m1;
  logic          span_done;
  logic          load;
  logic          hold_wr;

  assign wmask    = 8'hFF >> (2'd3 - ctrl[1:0]);
  assign par_calc = ctrl[5] ? ~ctrl[4] : (ctrl[4] ? ^(hold & wmask) : ~^(hold & wmask));

  always_comb begin
    span_m1 = ONE_BIT_M1;
    if (state == S_STOP && f_stop)
      span_m1 = (f_wl == 2'd0) ? ONE_HALF_M1 : TWO_BITS_M1;
  end

  assign span_done = baud_tick && ({1'b0, tick_cnt} == span_m1);
  assign load      = hold_full && (state == S_IDLE || (state == S_STOP && span_done));
  assign hold_wr   = reg_wr && (reg_addr == ADDR_W'(THR_ADDR)) && !hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_W'(LCR_ADDR))
        ctrl <= reg_wdata[5:0];
      if (hold_wr) begin
        hold      <= reg_wdata;
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      shreg    <= '0;
      tick_cnt <= '0;
      bit_idx  <= '0;
      f_wl     <= '0;
      f_stop   <= 1'b0;
      f_pen    <= 1'b0;
      f_par    <= 1'b0;
    end else if (load) begin
      state    <= S_START;
      shreg    <= hold;
      tick_cnt <= '0;
      bit_idx  <= '0;
      f_wl     <= ctrl[1:0];
      f_stop   <= ctrl[2];
      f_pen    <= ctrl[3];
      f_par    <= par_calc;
    end else if (state != S_IDLE && baud_tick) begin
      if (span_done) begin
        tick_cnt <= '0;
        case (state)
          S_START: state <= S_DATA;
          S_DATA: begin
            shreg <= shreg >> 1;
            if (bit_idx == {1'b0, f_wl} + 3'd4) begin
              state <= f_pen ? S_PAR : S_STOP;
            end else begin
              bit_idx <= bit_idx + 3'd1;
            end
          end
          S_PAR:   state <= S_STOP;
          default: state <= S_IDLE;
        endcase
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (state)
      S_START: ser_out = 1'b0;
      S_DATA:  ser_out = shreg[0];
      S_PAR:   ser_out = f_par;
      default: ser_out = 1'b1;
    endcase
  end

  assign tx_ready_n = hold_full;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(LCR_ADDR))
      reg_rdata = {2'b00, ctrl};
    else if (reg_addr == ADDR_W'(LSR_ADDR))
      reg_rdata = {1'b0, !hold_full && state == S_IDLE, !hold_full, 5'b0};
  end

  // R9
  idle_start_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_IDLE && state == S_START) |-> $past(hold_full));

  // R10
  full_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(THR_ADDR) && hold_full) |=> (hold == $past(hold)));

  // R7
  tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !baud_tick) |=> ($stable(state) && $stable(tick_cnt)));

  // R11
  frame_cfg_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START || state == S_DATA || state == S_PAR) |=> $stable({f_wl, f_stop, f_pen, f_par}));

  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_STOP && state == S_IDLE) |-> (ser_out && !hold_full));
endmodule

// File: tb/uart_frame_tx_tb_top.sv
`timescale 1ns/1ps
module uart_frame_tx_tb_top;
  localparam int TPB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [2:0] reg_addr = 3'd5;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ser_out;
  logic       tx_ready_n;

  uart_frame_tx #(.TICKS_PER_BIT(TPB)) dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ser_out(ser_out), .tx_ready_n(tx_ready_n));

  always #10 clk = ~clk;

  typedef struct {
    logic [7:0] d;
    int         len;
    bit         pen;
    bit         par;
    int         stop;
    bit         b2b;
    bit         junk;
    string      tag;
  } frame_t;

  frame_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  int tick_gap = 1;
  logic [5:0] cur_lcr = 6'h00;
  bit in_frame = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int got, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, expv);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic frame_t make_item(input logic [7:0] d, input logic [5:0] l, input bit b2b, input string tag);
    frame_t f;
    int ones;
    f.d    = d;
    f.len  = 5 + int'(l[1:0]);
    f.pen  = l[3];
    ones   = 0;
    for (int i = 0; i < f.len; i++) ones += int'(d[i]);
    if (l[5]) f.par = !l[4];
    else if (l[4]) f.par = (ones % 2) == 1;
    else f.par = (ones % 2) == 0;
    f.stop = !l[2] ? TPB : (f.len == 5 ? TPB + TPB / 2 : 2 * TPB);
    f.b2b  = b2b;
    f.junk = 0;
    f.tag  = tag;
    return f;
  endfunction

  function automatic logic level(input frame_t f, input int k);
    int b;
    b = k / TPB;
    if (b == 0) return 1'b0;
    if (b <= f.len) return f.d[b-1];
    if (f.pen && b == f.len + 1) return f.par;
    return 1'b1;
  endfunction

  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(posedge clk);
      #1;
      baud_tick = (cnt == 0);
      cnt = (cnt + 1 >= tick_gap) ? 0 : cnt + 1;
    end
  end

  // Monitor: pops one expected frame per start bit and checks every tick position.
  initial begin
    frame_t cur;
    int k, total, badk;
    bit bad, ended;
    logic gotv, expv;
    k = 0; total = 0; badk = 0; bad = 0; gotv = 0; expv = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      ended = 0;
      if (in_frame && k == total) begin
        in_frame = 0;
        ended = 1;
        if (cur.junk)
          chk(0, "R10", "frame sent with no expected byte", 1, 0);
        else if (bad)
          chk(0, cur.tag, $sformatf("frame 0x%02h line at tick %0d", cur.d, badk), int'(gotv), int'(expv));
        else
          chk(1, cur.tag, "frame", 0, 0);
      end
      if (!in_frame && ser_out == 1'b0) begin
        if (exp_q.size() == 0) begin
          cur = make_item(8'h00, 6'h03, 0, "R10");
          cur.junk = 1;
        end else begin
          cur = exp_q.pop_front();
          if (cur.b2b)
            chk(ended, "R9", "next start bit follows stop with no gap", int'(ended), 1);
        end
        in_frame = 1;
        k = 0;
        bad = 0;
        total = TPB * (1 + cur.len + int'(cur.pen)) + cur.stop;
      end
      if (in_frame) begin
        if (!cur.junk && !bad && ser_out !== level(cur, k)) begin
          bad = 1; badk = k; gotv = ser_out; expv = level(cur, k);
        end
        if (baud_tick) k++;
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
    @(posedge clk);
    #2;
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(posedge clk);
    #2;
    reg_wr = 1'b0; reg_addr = 3'd5;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = reg_rdata;
    reg_addr = 3'd5;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    rd_reg(3'd5, s);
    while (s[6] !== 1'b1) rd_reg(3'd5, s);
  endtask

  task automatic set_lcr(input logic [5:0] v);
    wait_idle();
    wr_reg(3'd3, {2'b00, v});
    cur_lcr = v;
  endtask

  // Driver: waits for the holding register, writes, and queues the expected frame.
  task automatic send(input logic [7:0] d, input string tag);
    logic [7:0] s;
    while (tx_ready_n) @(negedge clk);
    rd_reg(3'd5, s);
    wr_reg(3'd0, d);
    exp_q.push_back(make_item(d, cur_lcr, !s[6], tag));
  endtask

  initial begin
    #4000000;
    chk(0, "ALL", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    rd_reg(3'd3, v); chk(v == 8'h00, "R1", "control after reset", v, 8'h00);
    rd_reg(3'd5, v); chk(v == 8'h60, "R1", "status after reset", v, 8'h60);
    @(negedge clk);
    chk(tx_ready_n == 1'b0, "R1", "tx_ready_n after reset", tx_ready_n, 0);
    chk(ser_out == 1'b1, "R1", "line after reset", ser_out, 1);
    rd_reg(3'd1, v); chk(v == 8'h00, "R8", "unused address read", v, 0);

    // R3 R5 R2: 5-bit, even parity, 1 stop, back to back
    set_lcr(6'h18);
    send(8'h55, "R5"); send(8'hAA, "R3"); send(8'h5A, "R2"); send(8'hA5, "R5");
    // R4: 5-bit odd, 1.5 stop
    set_lcr(6'h0C);
    send(8'h55, "R4"); send(8'hA5, "R4");
    // R6: 6-bit stick, bit4=1 -> parity 0
    set_lcr(6'h39);
    send(8'h55, "R6"); send(8'hAA, "R6");
    // R6 R4: 7-bit stick, bit4=0 -> parity 1, 2 stop
    set_lcr(6'h2E);
    send(8'h5A, "R6"); send(8'hA5, "R4");
    // R5: 8-bit no parity
    set_lcr(6'h03);
    send(8'h55, "R5"); send(8'hAA, "R3");
    // R4: 8-bit odd, 2 stop; 6-bit even, 2 stop
    set_lcr(6'h0F);
    send(8'hA5, "R4");
    set_lcr(6'h1D);
    send(8'h5A, "R4");
    // R7: enables every third cycle, 7-bit even, 1 stop
    wait_idle();
    tick_gap = 3;
    set_lcr(6'h1A);
    send(8'h5A, "R7"); send(8'hC3, "R7");
    wait_idle();
    tick_gap = 1;

    // R8 R9 R10 R11: status, dropped write, mid-frame control change
    set_lcr(6'h03);
    wr_reg(3'd0, 8'h3C);
    exp_q.push_back(make_item(8'h3C, 6'h03, 0, "R11"));
    while (tx_ready_n) @(negedge clk);
    rd_reg(3'd5, v); chk(v == 8'h20, "R8", "status while shifting, holding empty", v, 8'h20);
    wr_reg(3'd0, 8'hC3);
    @(negedge clk);
    chk(tx_ready_n == 1'b1, "R9", "tx_ready_n with holding full", tx_ready_n, 1);
    rd_reg(3'd5, v); chk(v == 8'h00, "R8", "status with both full", v, 8'h00);
    wr_reg(3'd0, 8'h99);
    wr_reg(3'd3, 8'h1B);
    cur_lcr = 6'h1B;
    exp_q.push_back(make_item(8'hC3, 6'h1B, 1, "R11"));
    rd_reg(3'd3, v); chk(v == 8'h1B, "R8", "control read back", v, 8'h1B);
    wait_idle();
    rd_reg(3'd5, v); chk(v == 8'h60, "R8", "status when quiet", v, 8'h60);
    @(negedge clk);
    chk(tx_ready_n == 1'b0, "R9", "tx_ready_n when quiet", tx_ready_n, 0);

    repeat (400) @(posedge clk);
    chk(exp_q.size() == 0 && !in_frame, "R10", "expected frames left over", exp_q.size(), 0);
    finish_up();
  end
endmodule